// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of a RISC core whose subroutines each see 32 logical registers, R0 to R31, through a movable window over a larger physical store. A window pointer selects the active window. Ten registers (R0 to R9) are global and reach the same storage from every window. The remaining 22 logical registers are windowed: R10 to R15 carry values between a subroutine and its caller, R16 to R25 are private locals, and R26 to R31 carry values between a subroutine and the subroutines it calls. Adjacent windows overlap by six registers, so each window adds 16 new physical entries. With the default of 8 windows the store holds 10 + 16 × 8 = 138 entries.

A call strobe moves the pointer to the next window. In the same clock edge, the program counter on the link port is written into the chosen destination register of the new window. A return strobe moves the pointer back. Spilling to memory is handled elsewhere. When the window ring runs out, or a return goes past the oldest window, the block only raises a one-cycle flag. The core reads two operands combinationally and writes one result per clock.

Top module: `win_regfile`

## Requirements
- R1: After reset the window pointer is 0, both flags are 0, and every register reads 0.
- R2: With `wrEn` high and no call or return strobe, `wrData` is stored into logical register `wrAddr` of the active window at the clock edge. Either read port then returns it for the same logical number.
- R3: Logical R0 to R9 read and write the same storage whatever the window pointer is.
- R4: A call advances the window pointer by one, modulo `NUM_WIN`. A return alone moves it back by one, modulo `NUM_WIN`. When both strobes are high in the same cycle, it is a call only. With neither strobe high, the pointer holds.
- R5: After a call, the child's R10 to R15 are the same storage as the parent's R26 to R31. R16 to R25 are private to each window.
- R6: On a call, `linkPc` is written into logical register `linkDst` of the new window, not the old one.
- R7: In a cycle where the call or return strobe is high, the normal write port has no effect.
- R8: When a read port addresses the storage entry being written in the same cycle, it returns the value being written.
- R9: A call made while `NUM_WIN`-1 calls are outstanding raises `ovfFlag` for exactly the next cycle. The pointer still advances.
- R10: A return made with no outstanding calls raises `unfFlag` for exactly the next cycle. The pointer still moves back, wrapping from 0 to `NUM_WIN`-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 5 | Logical register number, read port A |
| rdDataA | output | DATA_W | Read data, port A (combinational) |
| rdAddrB | input | 5 | Logical register number, read port B |
| rdDataB | output | DATA_W | Read data, port B (combinational) |
| wrEn | input | 1 | Write enable, normal write port |
| wrAddr | input | 5 | Logical register number to write |
| wrData | input | DATA_W | Write data |
| callStb | input | 1 | Subroutine call strobe |
| retStb | input | 1 | Subroutine return strobe |
| linkPc | input | DATA_W | Program counter stored on a call |
| linkDst | input | 5 | Logical destination of the link value in the new window |
| winPtr | output | $clog2(NUM_WIN) | Active window pointer |
| ovfFlag | output | 1 | Window overflow, one-cycle pulse |
| unfFlag | output | 1 | Window underflow, one-cycle pulse |

## Verification
The windowing is exercised with one value each in the global, incoming, local and outgoing ranges, written in window 0. These values are then read back from a called window and again after the return. A global value that survives the call separates global addressing from windowed addressing. A parent's outgoing value that appears as the child's incoming value checks the overlap. A child local that reads 0 shows the locals are private. Writes made during call and return cycles, plus a same-cycle write and read, check that the normal port is dropped and that the bypass is present. A long run of calls, a return from depth zero and a combined call-and-return probe the pointer wrap, both flags, and the priority between the strobes.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int LOG_REGS = 32;
  localparam int LOG_W = 5;
  localparam int GLOBALS = 10;
  localparam int WIN_STRIDE = 16;

  typedef struct packed {
    logic wrEn;
    logic useLink;
  } wrStrobe_t;

  // Logical register number to physical index for a given window.
  function automatic int physIdx(input int wp, input int r, input int nWin);
    if (r < GLOBALS) return r;
    return GLOBALS + ((wp * WIN_STRIDE + (r - GLOBALS)) % (WIN_STRIDE * nWin));
  endfunction
endpackage

// File: rtl/wrf_control.sv
module wrf_control
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int PHYS_W = 8,
  parameter int WP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callStb,
  input  logic              retStb,
  input  logic              wrEn,
  input  logic [LOG_W-1:0]  wrAddr,
  input  logic [LOG_W-1:0]  linkDst,
  output logic [WP_W-1:0]   winPtr,
  output wrStrobe_t         stb,
  output logic [PHYS_W-1:0] wrIdx,
  output logic              ovfFlag,
  output logic              unfFlag
);
  localparam logic [WP_W-1:0] LAST_WIN = WP_W'(NUM_WIN - 1);

  logic [WP_W-1:0] nextUp, nextDn, depth;
  logic doCall, doRet;

  assign doCall = callStb;
  assign doRet  = retStb & ~callStb;
  assign nextUp = (winPtr == LAST_WIN) ? '0 : winPtr + 1'b1;
  assign nextDn = (winPtr == '0) ? LAST_WIN : winPtr - 1'b1;

  always_comb begin
    stb.useLink = doCall;
    stb.wrEn    = doCall | (wrEn & ~retStb);
    if (doCall) wrIdx = PHYS_W'(physIdx(int'(nextUp), int'(linkDst), NUM_WIN));
    else        wrIdx = PHYS_W'(physIdx(int'(winPtr), int'(wrAddr), NUM_WIN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winPtr  <= '0;
      depth   <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else begin
      ovfFlag <= doCall && (depth == LAST_WIN);
      unfFlag <= doRet && (depth == '0);
      if (doCall) begin
        winPtr <= nextUp;
        if (depth != LAST_WIN) depth <= depth + 1'b1;
      end else if (doRet) begin
        winPtr <= nextDn;
        if (depth != '0) depth <= depth - 1'b1;
      end
    end
  end

  // R4
  win_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    callStb |=> winPtr == (($past(winPtr) == LAST_WIN) ? '0 : $past(winPtr) + 1'b1));
  // R4
  win_dn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retStb && !callStb) |=> winPtr == (($past(winPtr) == '0) ? LAST_WIN : $past(winPtr) - 1'b1));
  // R4
  win_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!retStb && !callStb) |=> $stable(winPtr));
  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(callStb));
  // R10
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |-> $past(retStb && !callStb));
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovfFlag, unfFlag}));
endmodule

// File: rtl/wrf_datapath.sv
module wrf_datapath
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W = 32,
  parameter int PHYS_W = 8,
  parameter int WP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WP_W-1:0]   winPtr,
  input  wrStrobe_t         stb,
  input  logic [PHYS_W-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] linkPc,
  input  logic [LOG_W-1:0]  rdAddrA,
  input  logic [LOG_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int PHYS_REGS = GLOBALS + WIN_STRIDE * NUM_WIN;

  logic [DATA_W-1:0] store [PHYS_REGS];
  logic [DATA_W-1:0] wrVal;
  logic [PHYS_W-1:0] rdPhys [2];
  logic [LOG_W-1:0]  rdLog  [2];
  logic [DATA_W-1:0] rdOut  [2];

  assign wrVal = stb.useLink ? linkPc : wrData;
  assign rdLog[0] = rdAddrA;
  assign rdLog[1] = rdAddrB;
  assign rdDataA = rdOut[0];
  assign rdDataB = rdOut[1];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      rdPhys[p] = PHYS_W'(physIdx(int'(winPtr), int'(rdLog[p]), NUM_WIN));
      rdOut[p] = (stb.wrEn && wrIdx == rdPhys[p]) ? wrVal : store[rdPhys[p]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_REGS; i++) store[i] <= '0;
    end else if (stb.wrEn) begin
      store[wrIdx] <= wrVal;
    end
  end

  // R2
  store_upd_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> store[$past(wrIdx)] == $past(wrVal));
  // R6
  link_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.useLink |=> store[$past(wrIdx)] == $past(linkPc));
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W = 32,
  localparam int WP_W = $clog2(NUM_WIN),
  localparam int PHYS_W = $clog2(GLOBALS + WIN_STRIDE * NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [4:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              callStb,
  input  logic              retStb,
  input  logic [DATA_W-1:0] linkPc,
  input  logic [4:0]        linkDst,
  output logic [WP_W-1:0]   winPtr,
  output logic              ovfFlag,
  output logic              unfFlag
);
  wrStrobe_t         stb;
  logic [PHYS_W-1:0] wrIdx;

  wrf_control #(.NUM_WIN(NUM_WIN), .PHYS_W(PHYS_W), .WP_W(WP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .callStb(callStb), .retStb(retStb),
    .wrEn(wrEn), .wrAddr(wrAddr), .linkDst(linkDst), .winPtr(winPtr),
    .stb(stb), .wrIdx(wrIdx), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  wrf_datapath #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .PHYS_W(PHYS_W), .WP_W(WP_W)) u_dp (
    .clk(clk), .rstN(rstN), .winPtr(winPtr), .stb(stb), .wrIdx(wrIdx),
    .wrData(wrData), .linkPc(linkPc), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: tb/win_regfile_bench.sv
`timescale 1ns/1ps
module win_regfile_bench;
  localparam int N = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] rdAddrA = '0, rdAddrB = '0, wrAddr = '0, linkDst = '0;
  logic [DW-1:0] wrData = '0, linkPc = '0;
  logic wrEn = 1'b0, callStb = 1'b0, retStb = 1'b0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic [2:0] winPtr;
  logic ovfFlag, unfFlag;

  int checks = 0;
  int errors = 0;
  int expWp = 0;

  always #10 clk = ~clk;

  win_regfile #(.NUM_WIN(N), .DATA_W(DW)) u_win_regfile (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .callStb(callStb), .retStb(retStb), .linkPc(linkPc),
    .linkDst(linkDst), .winPtr(winPtr), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  // {logical register, value}, written in window 0
  localparam logic [36:0] VEC [6] = '{
    {5'd3,  32'h0000_0A03}, {5'd9,  32'h0000_0B09}, {5'd12, 32'h0000_0C12},
    {5'd20, 32'h0000_0D20}, {5'd28, 32'h0000_0E28}, {5'd31, 32'h0000_0F31}
  };

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readA(input logic [4:0] r, input logic [DW-1:0] exp, input string req);
    rdAddrA = r;
    #1;
    check(rdDataA === exp, req, rdDataA, exp);
  endtask

  task automatic writeReg(input logic [4:0] r, input logic [DW-1:0] d);
    wrEn = 1'b1; wrAddr = r; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(winPtr === 3'd0, "R1 ptr", DW'(winPtr), 0);
    check({ovfFlag, unfFlag} === 2'b00, "R1 flags", DW'({ovfFlag, unfFlag}), 0);
    readA(5'd5, 0, "R1 reg");
    rdAddrB = 5'd31; #1;
    check(rdDataB === 0, "R1 regB", rdDataB, 0);

    // R2 vector walk: write then read back on both ports
    foreach (VEC[i]) begin
      writeReg(VEC[i][36:32], VEC[i][31:0]);
      rdAddrB = VEC[i][36:32]; #1;
      check(rdDataB === VEC[i][31:0], "R2 portB", rdDataB, VEC[i][31:0]);
      readA(VEC[i][36:32], VEC[i][31:0], "R2 portA");
    end

    // R8 same-cycle bypass
    wrEn = 1'b1; wrAddr = 5'd7; wrData = 32'hB1B1_0007; rdAddrA = 5'd7; #1;
    check(rdDataA === 32'hB1B1_0007, "R8 bypass", rdDataA, 32'hB1B1_0007);
    tick(); wrEn = 1'b0;

    writeReg(5'd4,  32'h6100_0004);
    writeReg(5'd18, 32'h1000_0018);
    writeReg(5'd26, 32'h5000_0026);

    // Call with a concurrent normal write (R6, R7)
    callStb = 1'b1; linkPc = 32'h0000_4440; linkDst = 5'd16;
    wrEn = 1'b1; wrAddr = 5'd20; wrData = 32'hDEAD_0020;
    tick();
    callStb = 1'b0; wrEn = 1'b0;
    check(winPtr === 3'd1, "R4 call", DW'(winPtr), 1);
    readA(5'd4, 32'h6100_0004, "R3 global R4");
    readA(5'd9, 32'h0000_0B09, "R3 global R9");
    readA(5'd10, 32'h5000_0026, "R5 overlap");
    readA(5'd16, 32'h0000_4440, "R6 link");
    readA(5'd18, 0, "R5 private");

    writeReg(5'd18, 32'h2000_0018);
    writeReg(5'd10, 32'h7000_0010);

    // Return with a concurrent normal write (R7)
    retStb = 1'b1; wrEn = 1'b1; wrAddr = 5'd3; wrData = 32'hDEAD_0003;
    tick();
    retStb = 1'b0; wrEn = 1'b0;
    check(winPtr === 3'd0, "R4 return", DW'(winPtr), 0);
    readA(5'd26, 32'h7000_0010, "R5 return value");
    readA(5'd18, 32'h1000_0018, "R5 parent local");
    readA(5'd20, 32'h0000_0D20, "R7 call write dropped");
    readA(5'd3, 32'h0000_0A03, "R7 return write dropped");
    check({ovfFlag, unfFlag} === 2'b00, "R9 R10 quiet", DW'({ovfFlag, unfFlag}), 0);

    // R10 underflow at depth zero
    retStb = 1'b1; tick(); retStb = 1'b0;
    check(unfFlag === 1'b1, "R10 flag", DW'(unfFlag), 1);
    check(winPtr === 3'(N - 1), "R10 wrap", DW'(winPtr), N - 1);
    tick();
    check(unfFlag === 1'b0, "R10 pulse", DW'(unfFlag), 0);

    // R4 call and return together act as a call
    expWp = N - 1;
    callStb = 1'b1; retStb = 1'b1; tick(); retStb = 1'b0; callStb = 1'b0;
    expWp = (expWp + 1) % N;
    check(winPtr === 3'(expWp), "R4 call priority", DW'(winPtr), DW'(expWp));

    // R9 overflow: N-1 calls fit, the next one flags
    for (int k = 1; k < N - 1; k++) begin
      callStb = 1'b1; tick(); callStb = 1'b0;
      expWp = (expWp + 1) % N;
      check(ovfFlag === 1'b0, "R9 no overflow", DW'(ovfFlag), 0);
    end
    callStb = 1'b1; tick(); callStb = 1'b0;
    expWp = (expWp + 1) % N;
    check(ovfFlag === 1'b1, "R9 flag", DW'(ovfFlag), 1);
    check(winPtr === 3'(expWp), "R9 ptr advanced", DW'(winPtr), DW'(expWp));
    tick();
    check(ovfFlag === 1'b0, "R9 pulse", DW'(ovfFlag), 0);
    check(winPtr === 3'(expWp), "R4 hold", DW'(winPtr), DW'(expWp));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule